// File: doc/BRIEF.md
# Stream Memory Address Generator

This block expands one stream transfer command into the full series of word requests that the command implies. A command names a base word address, an element count, a signed stride, an addressing mode and a direction. Once it is accepted, the block emits one request per element on a valid/ready request port that feeds a separate memory controller. A load direction yields read requests, which fill the on-chip stream buffer. A store direction yields write requests, which drain it. The element number goes out with each request so that the buffer side knows which slot the word belongs to.

Four addressing modes are supported: linear, strided, bit-reversed and indexed. The indexed mode takes one index word per element from an input handshake port. It acts as a gather when loading and as a scatter when storing. When the last request has been taken, the block pulses a completion flag. Zero-length commands finish at once. Bit-reversed commands with a length that is not a power of two are refused and flagged. The block only generates addresses. It holds no data and does not drive memory pins.

Top module: `stream_addr_gen`

## Requirements
- R1: `cmd_ready` is high exactly when no stream is in progress. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high, and no command is taken while requests are pending.
- R2: Mode code 0 (linear) issues element i at address `base + i`, modulo 2^ADDR_W.
- R3: Mode code 1 (strided) issues element i at `base + i*stride`, where `stride` is a 16-bit two's-complement value. The sum wraps modulo 2^ADDR_W.
- R4: Mode code 3 (bit-reversed) with a power-of-two length N = 2^k issues element i at `base + rev_k(i)`. Here rev_k reverses the low k bits of i. For N = 1 the address is `base`.
- R5: In mode code 3, a length that is neither zero nor a power of two issues no request. Instead, `err` and `done` are both high for one cycle, in the cycle after the command is accepted.
- R6: Mode code 2 (indexed) issues element i at `base + idx_data`, with wrap, where `idx_data` is the i-th index word. `idx_ready` is high only in a cycle where the request handshake completes in indexed mode. While `idx_valid` is low, `req_valid` stays low.
- R7: Elements are issued in strictly ascending order 0 to len-1, and `req_elem` carries i. While `req_ready` is low, a pending request keeps its valid, address, element and direction unchanged.
- R8: `req_write` is 1 for every request of a store command (`cmd_store`=1) and 0 for every request of a load command.
- R9: `done` is high for exactly one cycle, in the cycle after the last request is accepted. A zero-length command issues no request and raises `done` in the cycle after it is accepted.
- R10: A new command can be accepted in the same cycle that `done` is high.
- R11: During and right after reset, `cmd_ready`=1, and `req_valid`, `idx_ready`, `done` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and can take a command |
| cmd_mode | input | 2 | 0 linear, 1 strided, 2 indexed, 3 bit-reversed |
| cmd_store | input | 1 | 1 = store (write requests), 0 = load (read requests) |
| cmd_base | input | ADDR_W | Base word address |
| cmd_len | input | CNT_W | Element count |
| cmd_stride | input | STRIDE_W | Signed stride for strided mode |
| idx_valid | input | 1 | Index word available |
| idx_ready | output | 1 | Index word consumed this cycle |
| idx_data | input | ADDR_W | Index word (offset from base) |
| req_valid | output | 1 | Memory request pending |
| req_ready | input | 1 | Memory controller takes the request |
| req_addr | output | ADDR_W | Word address of the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_elem | output | CNT_W | Element number within the stream |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal flag, raised together with done |

## Verification
The two functions that can fall in the same cycle are the completion pulse of one stream and the acceptance of the next command. The bench provokes this by offering a new command in the very cycle where `done` is sampled high, after a stream whose final request was taken under random `req_ready` stalls. It judges the overlap by checking that `cmd_ready` is high in that cycle, that the new stream begins at element 0 in the following cycle with the new mode and direction, and that no request of the old stream is issued again. A second overlap comes from indexed streams, where index consumption and the memory handshake must happen in the same cycle. Here the bench drops `idx_valid` at random and checks that `idx_ready` rises only when `req_ready` and `idx_valid` are both high.

// File: rtl/sag_pkg.sv
package sag_pkg;
   typedef enum logic [1:0] {
      SAG_LINEAR = 2'd0,
      SAG_STRIDE = 2'd1,
      SAG_INDEX  = 2'd2,
      SAG_BITREV = 2'd3
   } sag_mode_e;
endpackage

// File: rtl/sag_seq.sv
module sag_seq #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             quick_i,
   input  logic             bad_i,
   input  logic [CNT_W-1:0] len_i,
   input  logic             adv_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] elem_o,
   output logic             done_o,
   output logic             err_o
);
   logic [CNT_W-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         elem_o <= '0;
         last_q <= '0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (quick_i) begin
            done_o <= 1'b1;
            err_o  <= bad_i;
         end else if (start_i) begin
            busy_o <= 1'b1;
            elem_o <= '0;
            last_q <= len_i - CNT_W'(1);
         end else if (busy_o && adv_i) begin
            if (elem_o == last_q) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end else begin
               elem_o <= elem_o + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/sag_addr.sv
module sag_addr import sag_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int STRIDE_W   = 16,
   parameter bit MUL_STRIDE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  sag_mode_e           mode_i,
   input  logic                store_i,
   input  logic [ADDR_W-1:0]   base_i,
   input  logic [CNT_W-1:0]    len_i,
   input  logic [STRIDE_W-1:0] stride_i,
   input  logic [CNT_W-1:0]    elem_i,
   input  logic                adv_i,
   input  logic [ADDR_W-1:0]   idx_i,
   output logic [ADDR_W-1:0]   addr_o,
   output sag_mode_e           mode_o,
   output logic                store_o
);
   localparam int LG_W = $clog2(CNT_W + 1);

   logic [ADDR_W-1:0]   base_q;
   logic [STRIDE_W-1:0] stride_q;
   logic [LG_W-1:0]     lg_q;
   logic [ADDR_W-1:0]   stride_x;
   logic [ADDR_W-1:0]   off;
   logic [CNT_W-1:0]    rev;
   logic [CNT_W-1:0]    rev_sh;
   logic [LG_W-1:0]     sh;

   function automatic logic [LG_W-1:0] high_bit(input logic [CNT_W-1:0] v);
      logic [LG_W-1:0] r;
      r = '0;
      for (int b = 0; b < CNT_W; b++)
         if (v[b]) r = LG_W'(b);
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         stride_q <= '0;
         lg_q     <= '0;
         mode_o   <= SAG_LINEAR;
         store_o  <= 1'b0;
      end else if (load_i) begin
         base_q   <= base_i;
         stride_q <= stride_i;
         lg_q     <= high_bit(len_i);
         mode_o   <= mode_i;
         store_o  <= store_i;
      end
   end

   assign stride_x = {{(ADDR_W-STRIDE_W){stride_q[STRIDE_W-1]}}, stride_q};

   generate
      if (MUL_STRIDE) begin : g_mul
         assign off = ADDR_W'(elem_i) * stride_x;
      end else begin : g_acc
         logic [ADDR_W-1:0] run_q;
         always_ff @(posedge clk) begin
            if (!rst_n || load_i) run_q <= '0;
            else if (adv_i)       run_q <= run_q + stride_x;
         end
         assign off = run_q;
      end
   endgenerate

   for (genvar g = 0; g < CNT_W; g++) begin : g_rev
      assign rev[g] = elem_i[CNT_W-1-g];
   end
   assign sh     = LG_W'(CNT_W) - lg_q;
   assign rev_sh = rev >> sh;

   always_comb begin
      unique case (mode_o)
         SAG_LINEAR: addr_o = base_q + ADDR_W'(elem_i);
         SAG_STRIDE: addr_o = base_q + off;
         SAG_INDEX:  addr_o = base_q + idx_i;
         default:    addr_o = base_q + ADDR_W'(rev_sh);
      endcase
   end
endmodule

// File: rtl/stream_addr_gen.sv
module stream_addr_gen import sag_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int STRIDE_W   = 16,
   parameter bit MUL_STRIDE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [1:0]          cmd_mode,
   input  logic                cmd_store,
   input  logic [ADDR_W-1:0]   cmd_base,
   input  logic [CNT_W-1:0]    cmd_len,
   input  logic [STRIDE_W-1:0] cmd_stride,
   input  logic                idx_valid,
   output logic                idx_ready,
   input  logic [ADDR_W-1:0]   idx_data,
   output logic                req_valid,
   input  logic                req_ready,
   output logic [ADDR_W-1:0]   req_addr,
   output logic                req_write,
   output logic [CNT_W-1:0]    req_elem,
   output logic                done,
   output logic                err
);
   if (ADDR_W < CNT_W) begin : g_bad_addr_w
      $error("ADDR_W must be at least CNT_W");
   end
   if (STRIDE_W > ADDR_W || STRIDE_W < 1) begin : g_bad_stride_w
      $error("STRIDE_W must lie in 1..ADDR_W");
   end

   sag_mode_e mode_in, mode_q;
   logic      busy, take, quick, go, adv, bad, len_zero, pow2, is_idx;

   assign mode_in  = sag_mode_e'(cmd_mode);
   assign len_zero = (cmd_len == '0);
   assign pow2     = ((cmd_len & (cmd_len - CNT_W'(1))) == '0);
   assign bad      = (mode_in == SAG_BITREV) && !len_zero && !pow2;
   assign take     = cmd_valid && !busy;
   assign quick    = take && (len_zero || bad);
   assign go       = take && !quick;

   assign cmd_ready = !busy;
   assign is_idx    = (mode_q == SAG_INDEX);
   assign req_valid = busy && (!is_idx || idx_valid);
   assign adv       = req_valid && req_ready;
   assign idx_ready = busy && is_idx && idx_valid && req_ready;

   sag_seq #(.CNT_W(CNT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (go),
      .quick_i (quick),
      .bad_i   (bad),
      .len_i   (cmd_len),
      .adv_i   (adv),
      .busy_o  (busy),
      .elem_o  (req_elem),
      .done_o  (done),
      .err_o   (err)
   );

   sag_addr #(
      .ADDR_W     (ADDR_W),
      .CNT_W      (CNT_W),
      .STRIDE_W   (STRIDE_W),
      .MUL_STRIDE (MUL_STRIDE)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (go),
      .mode_i   (mode_in),
      .store_i  (cmd_store),
      .base_i   (cmd_base),
      .len_i    (cmd_len),
      .stride_i (cmd_stride),
      .elem_i   (req_elem),
      .adv_i    (adv),
      .idx_i    (idx_data),
      .addr_o   (req_addr),
      .mode_o   (mode_q),
      .store_o  (req_write)
   );
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic [CNT_W-1:0]  req_elem,
   input logic              idx_valid,
   input logic              idx_ready,
   input logic              done,
   input logic              err
);
   // R1
   busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !cmd_ready);

   // R7 (index source keeps its word while waiting, as the handshake requires)
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                     && $stable(req_elem) && $stable(req_write)));

   // R7
   ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_valid || req_elem == $past(req_elem) + CNT_W'(1)));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!req_valid && cmd_ready));

   // R5
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R6
   idx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_ready |-> (req_valid && req_ready && idx_valid));
endmodule

bind stream_addr_gen sag_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sag_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .req_write (req_write),
   .req_elem  (req_elem),
   .idx_valid (idx_valid),
   .idx_ready (idx_ready),
   .done      (done),
   .err       (err)
);

// File: tb/stream_addr_gen_tb.sv
module stream_addr_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_mode = '0;
   logic        cmd_store = 1'b0;
   logic [31:0] cmd_base = '0;
   logic [15:0] cmd_len = '0;
   logic [15:0] cmd_stride = '0;
   logic        idx_valid = 1'b0;
   logic        idx_ready;
   logic [31:0] idx_data = '0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr;
   logic        req_write;
   logic [15:0] req_elem;
   logic        done;
   logic        err;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stream_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
      .cmd_store(cmd_store), .cmd_base(cmd_base), .cmd_len(cmd_len),
      .cmd_stride(cmd_stride),
      .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_elem(req_elem),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] idx_word(input int k);
      return 32'h0040_0000 ^ (32'(k) * 32'h9E37_79B1);
   endfunction

   function automatic logic [31:0] exp_addr(input logic [1:0] m, input logic [31:0] b,
                                            input logic [15:0] s, input logic [15:0] n, input int k);
      logic [31:0] r;
      int lg;
      r = '0;
      case (m)
         2'd0: return b + 32'(k);
         2'd1: return b + 32'(k) * {{16{s[15]}}, s};
         2'd2: return b + idx_word(k);
         default: begin
            lg = 0;
            while ((32'd1 << lg) < 32'(n)) lg++;
            for (int j = 0; j < lg; j++) r[lg-1-j] = k[j];
            return b + r;
         end
      endcase
   endfunction

   // drives a command in the current low phase; returns just after the accepting edge
   task automatic send_cmd(input logic [1:0] m, input bit st, input logic [31:0] b,
                           input logic [15:0] n, input logic [15:0] s);
      cmd_mode = m; cmd_store = st; cmd_base = b; cmd_len = n; cmd_stride = s;
      cmd_valid = 1'b1;
      #1;
      chk(cmd_ready == 1'b1, "R1 cmd_ready when idle", 32'(cmd_ready), 32'd1);
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   // collects the requests; returns in the done cycle (negedge + 1)
   task automatic collect(input logic [1:0] m, input bit st, input logic [31:0] b,
                          input logic [15:0] n, input logic [15:0] s);
      int k = 0;
      bit pend = 1'b0;
      int guard = 0;
      while (k < int'(n) && guard < 20000) begin
         @(negedge clk);
         guard++;
         req_ready = ($urandom % 4) != 0;
         if (!pend) pend = ($urandom % 3) != 0;
         idx_valid = pend;
         idx_data  = idx_word(k);
         #1;
         chk(cmd_ready == 1'b0, "R1 busy blocks cmd", 32'(cmd_ready), 32'd0);
         if (m == 2'd2 && !idx_valid)
            chk(req_valid == 1'b0, "R6 stall without index", 32'(req_valid), 32'd0);
         else
            chk(req_valid == 1'b1, "R7 request pending", 32'(req_valid), 32'd1);
         if (m == 2'd2)
            chk(idx_ready == (idx_valid && req_ready), "R6 idx_ready", 32'(idx_ready),
                32'(idx_valid && req_ready));
         else
            chk(idx_ready == 1'b0, "R6 idx_ready outside indexed", 32'(idx_ready), 32'd0);
         if (req_valid) begin
            chk(req_elem == 16'(k), "R7 element order", 32'(req_elem), 32'(k));
            chk(req_addr == exp_addr(m, b, s, n, k),
                m == 2'd0 ? "R2 linear addr" : m == 2'd1 ? "R3 strided addr" :
                m == 2'd2 ? "R6 indexed addr" : "R4 bitrev addr",
                req_addr, exp_addr(m, b, s, n, k));
            chk(req_write == st, "R8 direction", 32'(req_write), 32'(st));
            if (req_ready) begin
               k++;
               pend = 1'b0;
            end
         end
      end
      if (guard >= 20000) chk(1'b0, "R7 stream stalled", 32'(k), 32'(n));
      @(negedge clk);
      req_ready = 1'b0;
      idx_valid = 1'b0;
      #1;
      chk(done == 1'b1, "R9 done after last request", 32'(done), 32'd1);
      chk(err == 1'b0, "R9 no err on normal stream", 32'(err), 32'd0);
      chk(req_valid == 1'b0, "R9 no request after last", 32'(req_valid), 32'd0);
   endtask

   task automatic quick_cmd(input logic [1:0] m, input logic [15:0] n, input bit exp_err);
      @(negedge clk);
      send_cmd(m, 1'b0, 32'h0000_1000, n, 16'd1);
      @(negedge clk); #1;
      chk(done == 1'b1, exp_err ? "R5 done on refusal" : "R9 zero-length done", 32'(done), 32'd1);
      chk(err == exp_err, exp_err ? "R5 err flag" : "R9 zero-length no err", 32'(err), 32'(exp_err));
      chk(req_valid == 1'b0, exp_err ? "R5 no request" : "R9 no request", 32'(req_valid), 32'd0);
      @(negedge clk); #1;
      chk(req_valid == 1'b0 && done == 1'b0, exp_err ? "R5 stays idle" : "R9 pulse one cycle",
          32'({req_valid, done}), 32'd0);
   endtask

   task automatic stream(input logic [1:0] m, input bit st, input logic [31:0] b,
                         input logic [15:0] n, input logic [15:0] s);
      @(negedge clk);
      send_cmd(m, st, b, n, s);
      collect(m, st, b, n, s);
      @(negedge clk); #1;
      chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      chk(cmd_ready == 1'b1, "R11 reset cmd_ready", 32'(cmd_ready), 32'd1);
      chk(req_valid == 1'b0 && idx_ready == 1'b0, "R11 reset no request", 32'({req_valid, idx_ready}), 32'd0);
      chk(done == 1'b0 && err == 1'b0, "R11 reset flags", 32'({done, err}), 32'd0);
      @(negedge clk) rst_n = 1'b1;

      // directed corner cases
      stream(2'd0, 1'b1, 32'hFFFF_FFFD, 16'd6, 16'd0);     // R2 wrap, store
      stream(2'd1, 1'b0, 32'h0000_0100, 16'd7, 16'hFFFD);  // R3 negative stride
      stream(2'd1, 1'b1, 32'h0000_0000, 16'd4, 16'h7FFF);  // R3 largest stride
      stream(2'd3, 1'b0, 32'h0002_0000, 16'd8, 16'd0);     // R4 N=8
      stream(2'd3, 1'b1, 32'h0002_0000, 16'd1, 16'd0);     // R4 N=1
      stream(2'd3, 1'b0, 32'h0003_0000, 16'd64, 16'd0);    // R4 N=64
      stream(2'd2, 1'b0, 32'h0010_0000, 16'd9, 16'd0);     // R6 gather
      stream(2'd2, 1'b1, 32'hFFF0_0000, 16'd5, 16'd0);     // R6 scatter
      quick_cmd(2'd3, 16'd6, 1'b1);                        // R5
      quick_cmd(2'd3, 16'd3, 1'b1);                        // R5
      quick_cmd(2'd0, 16'd0, 1'b0);                        // R9 zero length
      quick_cmd(2'd3, 16'd0, 1'b0);                        // R9 zero length, bitrev

      // R10: next command offered in the done cycle
      @(negedge clk);
      send_cmd(2'd1, 1'b0, 32'h0000_4000, 16'd5, 16'd3);
      collect(2'd1, 1'b0, 32'h0000_4000, 16'd5, 16'd3);
      chk(cmd_ready == 1'b1, "R10 ready in done cycle", 32'(cmd_ready), 32'd1);
      send_cmd(2'd2, 1'b1, 32'h0000_8000, 16'd4, 16'd0);
      collect(2'd2, 1'b1, 32'h0000_8000, 16'd4, 16'd0);
      send_cmd(2'd0, 1'b0, 32'h0000_0010, 16'd3, 16'd0);
      collect(2'd0, 1'b0, 32'h0000_0010, 16'd3, 16'd0);

      // constrained random commands
      for (int t = 0; t < 60; t++) begin
         logic [1:0]  m;
         logic [15:0] n;
         m = 2'($urandom % 4);
         if (m == 2'd3) n = 16'd1 << ($urandom % 7);
         else           n = 16'($urandom % 33);
         if (n == 0) quick_cmd(m, n, 1'b0);
         else stream(m, 1'($urandom % 2), $urandom, n, 16'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule